// File: doc/BRIEF.md
# Linked-Descriptor Frame Fetcher

The block pulls frame pixels out of system memory for a display pipeline. It does not hold a base address and a length in registers; instead each frame is described by a small record in memory. Every record is four consecutive 32-bit words. In ascending address order they are the address of the following record, the byte address of the frame buffer, a frame tag, and a command word. Software writes the address of the first record and the fetcher starts from there. It reads the record, streams the frame words out through a small FIFO, and moves on to the following record. A record that names itself as its successor refreshes the same picture for ever.

Frame data is read in bursts whose size comes from a control field, and the last burst of a frame is cut short. A burst is issued only when the FIFO has room for every word already requested plus the new burst, so responses never need to be throttled. The command word carries the frame length and two requests for start-of-frame and end-of-frame flags. A third flag reports that the display side wanted a word and none was there. All three flags are sticky and are cleared by writing ones. The interrupt line is the OR of the flags that are enabled.

The memory port issues one request at a time with a byte address and a word count. It returns words in order, one per cycle at most. The first word comes back no earlier than the cycle after the request is granted.

Top module: `chain_frame_fetch`

## Requirements
- R1: Writing the start address (reg_sel = 0) while the fetcher is idle makes it issue a 4-word read at that address. It takes the returned words as successor address, buffer address, frame tag and command, in that order. After that start write it also leaves the idle state.
- R2: The frame words are read from consecutive addresses starting at the buffer address. They appear on the output in address order, and exactly as many as command bits 11:0 give.
- R3: Control bits 29:28 choose the burst size: 0 gives 4 words, 1 gives 8, and 2 or 3 give 16. Every frame read is of that size except the last of a frame, which carries only the words remaining.
- R4: After the last word of a frame has been received, the fetcher reads the record at the successor address. A record whose successor is itself therefore repeats its frame.
- R5: The frame_id output takes the tag word of a record once that record has been fully read. It keeps that value while the frame is being fetched.
- R6: Flag bit 0 (start of frame) is set when a record with command bit 15 set has been read. Flag bit 1 (end of frame) is set when the last word of a frame whose command bit 16 is set has been received.
- R7: Flags stay set until a write with reg_sel = 2 has a 1 in the flag's bit position (bit 0, 1 or 2). That write clears only those bits.
- R8: irq is high exactly when some flag is set whose enable is set. The enables are control bit 12 for flag 0, control bit 13 for flag 1 and control bit 11 for flag 2. The control register is written with reg_sel = 1.
- R9: Flag bit 2 (underrun) is set when, during a frame, out_ready is high and no output word is available. It is not set while out_ready is held low.
- R10: The words requested but not yet delivered never exceed the FIFO depth (16 by default). While out_ready is low, out_valid and out_data hold.
- R11: A record with length 0 causes no frame read. Its end-of-frame request still sets flag bit 1, and the fetcher goes straight on to the successor record.
- R12: After reset nothing is requested or output, flags and irq are 0, and frame_id is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 start address, 1 control, 2 flag clear |
| reg_wdata | input | 32 | Register write data |
| frame_id | output | 32 | Tag of the record most recently loaded |
| flags | output | 3 | Sticky flags: bit0 start, bit1 end, bit2 underrun |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Read request valid |
| mem_addr | output | 32 | Read byte address |
| mem_len | output | 5 | Read length in words (1 to 16) |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output word |
| out_ready | input | 1 | Downstream accepts the word |

## Verification
Suppose the record-word index or the remaining-word counters go wrong inside the fetcher. The bench would see a wrong address or length in the logged read requests within a burst or two, and a shifted or truncated word stream at the output. Suppose instead the room calculation is wrong while the sink is stalled. The total requested would run past the FIFO depth, and the logged request sum exposes that once the fetcher has been stalled for a few hundred cycles. Flag faults show at the flags and irq ports as soon as a record has loaded or its frame has ended.

// File: rtl/cff_pkg.sv
package cff_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DREQ,
        ST_DWAIT,
        ST_FREQ,
        ST_FDRAIN
    } cff_state_e;

    localparam int CMD_SOF_BIT = 15;
    localparam int CMD_EOF_BIT = 16;
    localparam int CTL_UNDR_EN = 11;
    localparam int CTL_SOF_EN  = 12;
    localparam int CTL_EOF_EN  = 13;
    localparam int CTL_BURST_LO = 28;
    localparam int DESC_WORDS  = 4;
endpackage

// File: rtl/cff_fifo.sv
module cff_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic          valid,
    output logic [W-1:0]  data,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } fifo_t;

    fifo_t q, d;
    logic [W-1:0] store_q [DEPTH];
    logic do_pop;

    always_comb begin
        d      = q;
        do_pop = pop && (q.cnt != '0);
        if (push) d.wptr = q.wptr + 1'b1;
        if (do_pop) d.rptr = q.rptr + 1'b1;
        d.cnt = q.cnt + CW'(push) - CW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push) store_q[q.wptr] <= push_data;
    end

    assign valid = (q.cnt != '0);
    assign data  = store_q[q.rptr];
    assign count = q.cnt;

    // R10
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && !do_pop |-> count < CW'(DEPTH));
endmodule

// File: rtl/cff_regs.sv
module cff_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_we,
    input  logic [4:0] ctl_in,
    input  logic       clr_we,
    input  logic [2:0] clr_in,
    input  logic [2:0] set_ev,
    output logic [1:0] burst_sel,
    output logic [2:0] flags,
    output logic       irq
);
    typedef struct packed {
        logic [1:0] burst;
        logic [2:0] en;
        logic [2:0] flg;
    } regs_t;

    regs_t q, d;
    logic [2:0] clr_mask;

    always_comb begin
        d        = q;
        clr_mask = clr_we ? clr_in : 3'b000;
        if (ctl_we) begin
            d.burst = ctl_in[4:3];
            d.en    = {ctl_in[0], ctl_in[2], ctl_in[1]};
        end
        d.flg = (q.flg & ~clr_mask) | set_ev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign burst_sel = q.burst;
    assign flags     = q.flg;
    assign irq       = |(q.flg & q.en);

    // R7
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/cff_seq.sv
module cff_seq
    import cff_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LEN_W = 12,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int SW   = LEN_W + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [31:0]   start_addr,
    input  logic [1:0]    burst_sel,
    input  logic [CW-1:0] fifo_count,
    output logic          mem_req,
    output logic [31:0]   mem_addr,
    output logic [4:0]    mem_len,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata,
    output logic          push,
    output logic          sof_ev,
    output logic          eof_ev,
    output logic          in_frame,
    output logic [31:0]   frame_id
);
    typedef struct packed {
        cff_state_e       st;
        logic [31:0]      dptr;
        logic [31:0]      nxt;
        logic [31:0]      faddr;
        logic [31:0]      tag;
        logic [31:0]      fid;
        logic [1:0]       widx;
        logic [LEN_W-1:0] req_left;
        logic [LEN_W-1:0] rx_left;
        logic             eof_req;
    } seq_t;

    seq_t q, d;
    logic [LEN_W-1:0] bl, blen, outst, len;
    logic [SW-1:0]    need;
    logic             room_ok;

    always_comb begin
        d        = q;
        mem_req  = 1'b0;
        mem_addr = q.dptr;
        mem_len  = 5'(DESC_WORDS);
        push     = 1'b0;
        sof_ev   = 1'b0;
        eof_ev   = 1'b0;
        len      = mem_rdata[LEN_W-1:0];
        case (burst_sel)
            2'd0:    bl = LEN_W'(4);
            2'd1:    bl = LEN_W'(8);
            default: bl = LEN_W'(16);
        endcase
        blen    = (q.req_left < bl) ? q.req_left : bl;
        outst   = q.rx_left - q.req_left;
        need    = SW'(outst) + SW'(fifo_count) + SW'(blen);
        room_ok = need <= SW'(DEPTH);
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.dptr = start_addr;
                    d.st   = ST_DREQ;
                end
            end
            ST_DREQ: begin
                mem_req = 1'b1;
                if (mem_gnt) begin
                    d.st   = ST_DWAIT;
                    d.widx = 2'd0;
                end
            end
            ST_DWAIT: begin
                if (mem_rvalid) begin
                    d.widx = q.widx + 2'd1;
                    case (q.widx)
                        2'd0: d.nxt   = mem_rdata;
                        2'd1: d.faddr = mem_rdata;
                        2'd2: d.tag   = mem_rdata;
                        default: begin
                            d.fid      = q.tag;
                            d.req_left = len;
                            d.rx_left  = len;
                            d.eof_req  = mem_rdata[CMD_EOF_BIT];
                            sof_ev     = mem_rdata[CMD_SOF_BIT];
                            if (len == '0) begin
                                eof_ev = mem_rdata[CMD_EOF_BIT];
                                d.dptr = q.nxt;
                                d.st   = ST_DREQ;
                            end else begin
                                d.st = ST_FREQ;
                            end
                        end
                    endcase
                end
            end
            ST_FREQ, ST_FDRAIN: begin
                if (mem_rvalid) begin
                    push      = 1'b1;
                    d.rx_left = q.rx_left - 1'b1;
                end
                if (q.st == ST_FREQ && room_ok) begin
                    mem_req  = 1'b1;
                    mem_addr = q.faddr;
                    mem_len  = blen[4:0];
                    if (mem_gnt) begin
                        d.faddr    = q.faddr + {blen[29:0], 2'b00};
                        d.req_left = q.req_left - blen;
                        if (q.req_left == blen) d.st = ST_FDRAIN;
                    end
                end
                if (q.st == ST_FDRAIN && mem_rvalid && q.rx_left == LEN_W'(1)) begin
                    eof_ev = q.eof_req;
                    d.dptr = q.nxt;
                    d.st   = ST_DREQ;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_frame = (q.st == ST_FREQ) || (q.st == ST_FDRAIN);
    assign frame_id = q.fid;

    // R10
    room_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_frame |-> (SW'(outst) + SW'(fifo_count)) <= SW'(DEPTH));
    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_len));
    // R3
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_len != 5'd0) && (mem_len <= 5'd16));
    // R1
    start_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !mem_req && !in_frame && !mem_rvalid && q.st == ST_IDLE |=> mem_req);
endmodule

// File: rtl/chain_frame_fetch.sv
module chain_frame_fetch #(
    parameter int DEPTH = 16,
    parameter int LEN_W = 12,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] frame_id,
    output logic [2:0]  flags,
    output logic        irq,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    output logic [4:0]  mem_len,
    input  logic        mem_gnt,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        out_valid,
    output logic [31:0] out_data,
    input  logic        out_ready
);
    import cff_pkg::*;

    logic [1:0]    burst_sel;
    logic [CW-1:0] fifo_count;
    logic          push, sof_ev, eof_ev, in_frame, undr_ev;

    assign undr_ev = in_frame && out_ready && !out_valid;

    cff_regs regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (reg_we && reg_sel == 2'd1),
        .ctl_in    ({reg_wdata[CTL_BURST_LO+1:CTL_BURST_LO], reg_wdata[CTL_EOF_EN],
                     reg_wdata[CTL_SOF_EN], reg_wdata[CTL_UNDR_EN]}),
        .clr_we    (reg_we && reg_sel == 2'd2),
        .clr_in    (reg_wdata[2:0]),
        .set_ev    ({undr_ev, eof_ev, sof_ev}),
        .burst_sel (burst_sel),
        .flags     (flags),
        .irq       (irq)
    );

    cff_seq #(.DEPTH(DEPTH), .LEN_W(LEN_W)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (reg_we && reg_sel == 2'd0),
        .start_addr (reg_wdata),
        .burst_sel  (burst_sel),
        .fifo_count (fifo_count),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_len    (mem_len),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .push       (push),
        .sof_ev     (sof_ev),
        .eof_ev     (eof_ev),
        .in_frame   (in_frame),
        .frame_id   (frame_id)
    );

    cff_fifo #(.W(32), .DEPTH(DEPTH)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (mem_rdata),
        .pop       (out_ready),
        .valid     (out_valid),
        .data      (out_data),
        .count     (fifo_count)
    );

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: tb/chain_frame_fetch_tb.sv
module chain_frame_fetch_tb_top;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] frame_id;
    logic [2:0]  flags;
    logic        irq;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [4:0]  mem_len;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_ready = 1'b0;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [31:0] mem [1024];
    int  pend_a[$];
    int  pend_t[$];
    int  log_a[$];
    int  log_l[$];
    logic [31:0] got[$];

    always #2.5 clk = ~clk;

    chain_frame_fetch dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .frame_id(frame_id), .flags(flags), .irq(irq),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    always begin
        @(negedge clk);
        if (!rst_n) begin
            pend_a.delete();
            pend_t.delete();
        end else if (mem_req && mem_gnt) begin
            log_a.push_back(int'(mem_addr));
            log_l.push_back(int'(mem_len));
            for (int k = 0; k < int'(mem_len); k++) begin
                pend_a.push_back(int'(mem_addr) + 4 * k);
                pend_t.push_back(cyc + LAT);
            end
        end
        if (rst_n && out_valid && out_ready) got.push_back(out_data);
        @(posedge clk);
        #1;
        cyc++;
        mem_gnt = (cyc % 3) != 0;
        if (pend_a.size() > 0 && pend_t[0] <= cyc) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mem[(pend_a[0] >> 2) & 1023];
            void'(pend_a.pop_front());
            void'(pend_t.pop_front());
        end else begin
            mem_rvalid = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; reg_we = 1'b0; out_ready = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        log_a.delete(); log_l.delete(); got.delete();
        for (int i = 0; i < 1024; i++) mem[i] = 32'h5A00_0000 + i;
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic put_desc(input int a, input int nxt, input int buf_a, input int tag,
                            input int cmd);
        mem[a >> 2]       = nxt;
        mem[(a >> 2) + 1] = buf_a;
        mem[(a >> 2) + 2] = tag;
        mem[(a >> 2) + 3] = cmd;
    endtask

    task automatic wait_words(input int n);
        for (int i = 0; i < 5000 && got.size() < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk(!mem_req && !out_valid, "R12 idle outputs", {30'd0, mem_req, out_valid}, 32'd0);
        chk(flags == 3'd0 && !irq, "R12 flags/irq", {28'd0, irq, flags}, 32'd0);
        chk(frame_id == 32'd0, "R12 frame_id", frame_id, 32'd0);
    endtask

    task automatic t_chain();
        int exp_a[8] = '{'h100, 'h400, 'h410, 'h420, 'h140, 'h800, 'h810, 'h140};
        int exp_l[8] = '{4, 4, 4, 2, 4, 4, 1, 4};
        do_reset();
        put_desc('h100, 'h140, 'h400, 'h1111, 10 | (1 << 15));
        put_desc('h140, 'h140, 'h800, 'h2222, 5 | (1 << 16));
        out_ready = 1'b1;
        wr(2'd0, 32'h100);
        wait_words(1);
        chk(frame_id == 32'h1111, "R5 first tag", frame_id, 32'h1111);
        chk(flags[1:0] == 2'b01, "R6 sof set eof clear", {30'd0, flags[1:0]}, 32'd1);
        wait_words(25);
        repeat (20) @(negedge clk);
        chk(got.size() >= 25, "R2 word count", got.size(), 25);
        if (got.size() >= 25) begin
            for (int k = 0; k < 25; k++) begin
                logic [31:0] e;
                e = (k < 10) ? 32'h5A00_0000 + 'h100 + k
                             : 32'h5A00_0000 + 'h200 + ((k - 10) % 5);
                chk(got[k] == e, (k < 10) ? "R2 frame word" : "R4 repeated word", got[k], e);
            end
        end
        chk(log_a.size() >= 8, "R1 request count", log_a.size(), 8);
        if (log_a.size() >= 8) begin
            for (int k = 0; k < 8; k++) begin
                chk(log_a[k] == exp_a[k], (k == 0) ? "R1 desc addr" : "R4 req addr", log_a[k], exp_a[k]);
                chk(log_l[k] == exp_l[k], "R3 req len", log_l[k], exp_l[k]);
            end
        end
        chk(frame_id == 32'h2222, "R5 second tag", frame_id, 32'h2222);
        chk(flags == 3'b111, "R6 R9 all flags", {29'd0, flags}, 32'd7);
        wr(2'd1, 32'd0);
        @(negedge clk);
        chk(!irq, "R8 no enables", {31'd0, irq}, 32'd0);
        wr(2'd1, 32'h0000_1000);
        @(negedge clk);
        chk(irq, "R8 sof enabled", {31'd0, irq}, 32'd1);
        wr(2'd2, 32'd1);
        @(negedge clk);
        chk(flags[0] == 1'b0, "R7 sof cleared", {31'd0, flags[0]}, 32'd0);
        chk(flags[2] == 1'b1, "R7 others kept", {31'd0, flags[2]}, 32'd1);
        chk(!irq, "R8 irq after clear", {31'd0, irq}, 32'd0);
        wr(2'd1, 32'h0000_0800);
        @(negedge clk);
        chk(irq, "R8 underrun enabled", {31'd0, irq}, 32'd1);
    endtask

    task automatic t_burst(input int sel, input int len);
        int bl, rem, a, k;
        do_reset();
        put_desc('h100, 'h100, 'h400, 'h33, len);
        out_ready = 1'b1;
        wr(2'd1, sel << 28);
        wr(2'd0, 32'h100);
        wait_words(len);
        repeat (30) @(negedge clk);
        bl  = (sel == 0) ? 4 : (sel == 1) ? 8 : 16;
        rem = len;
        a   = 'h400;
        k   = 1;
        while (rem > 0) begin
            int e;
            e = (rem < bl) ? rem : bl;
            if (k < log_a.size()) begin
                chk(log_a[k] == a, "R3 burst addr", log_a[k], a);
                chk(log_l[k] == e, "R3 burst len", log_l[k], e);
            end else begin
                chk(0, "R3 burst missing", k, log_a.size());
            end
            a += 4 * e; rem -= e; k++;
        end
        if (k < log_a.size()) chk(log_a[k] == 'h100, "R4 self reload", log_a[k], 'h100);
        else chk(0, "R4 self reload missing", k, log_a.size());
    endtask

    task automatic t_backpressure();
        int sum;
        do_reset();
        put_desc('h100, 'h100, 'h400, 'h44, 40);
        wr(2'd0, 32'h100);
        repeat (200) @(negedge clk);
        sum = 0;
        for (int k = 1; k < log_a.size(); k++) sum += log_l[k];
        chk(sum == 16, "R10 requested words", sum, 16);
        chk(out_valid && out_data == 32'h5A00_0100, "R10 held word", out_data, 32'h5A00_0100);
        chk(flags[2] == 1'b0, "R9 no underrun when stalled", {31'd0, flags[2]}, 32'd0);
        @(posedge clk); #1;
        out_ready = 1'b1;
        wait_words(40);
        chk(got.size() >= 40, "R10 drained count", got.size(), 40);
        for (int k = 0; k < 40 && k < got.size(); k++)
            chk(got[k] == 32'h5A00_0100 + k, "R10 order after stall", got[k], 32'h5A00_0100 + k);
    endtask

    task automatic t_zero();
        do_reset();
        put_desc('h100, 'h140, 'h400, 'h55, 1 << 16);
        put_desc('h140, 'h140, 'h800, 'h66, 3);
        out_ready = 1'b1;
        wr(2'd0, 32'h100);
        wait_words(3);
        chk(log_a.size() >= 2 && log_a[1] == 'h140, "R11 next desc read", log_a.size() >= 2 ? log_a[1] : 0, 'h140);
        chk(flags[1] == 1'b1, "R11 eof from empty frame", {31'd0, flags[1]}, 32'd1);
        for (int k = 0; k < 3 && k < got.size(); k++)
            chk(got[k] == 32'h5A00_0200 + k, "R11 following frame word", got[k], 32'h5A00_0200 + k);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_chain();
        t_burst(1, 10);
        t_burst(2, 20);
        t_burst(3, 16);
        t_burst(0, 3);
        t_backpressure();
        t_zero();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule